// File: doc/BRIEF.md
# Two-Way LRU Word Cache

This block is a small read cache that sits between a pipeline's data port and a slow main memory. It holds eight 32-bit words, arranged as four sets of two ways. Each line is a single word, so an address is made of a tag and a set index, with no offset inside a line. Loads that find their word return it combinationally in the cycle they are presented. A load that misses holds the requester for a fixed penalty of five cycles. During that time the word is read from main memory and written into the set, and the held request then completes as a hit.

Stores go straight through to main memory in the cycle they are presented. A store never brings a line into the cache. When a store finds its word already cached, the cached copy is updated as well, so later loads see the new value. Replacement within a set uses true least-recently-used order, and only loads (hits and fills) change that order. A counter in hardware adds up the stall cycles that read misses cause.

The requester must keep `req_valid`, `req_we` and `req_addr` steady while `stall` is high.

Top module: `lru_word_cache`

## Requirements
- R1: After reset every line is invalid, `stall` is 0, `miss_total` is 0, and the first load to any address misses.
- R2: With the default four sets, the set index is address bits [3:2] and the tag is bits [31:4]. Bits [1:0] are ignored. Addresses that differ only in bits [1:0] name the same word.
- R3: A load that hits returns the cached word on `rd_data`, with `req_ready` at 1 and `stall` at 0, in the same cycle the load is presented.
- R4: A load that misses keeps `stall` at 1 and `req_ready` at 0 for exactly five cycles, starting with the cycle in which the load is presented.
  - During those cycles `mem_rd` is 1 and `mem_addr` carries the load address.
  - `mem_rdata` is captured at the end of the fifth cycle.
  - In the sixth cycle the held load completes as a hit.
- R5: `miss_total` grows by exactly 5 at the clock edge that ends the first cycle of each load miss. Load hits and stores leave it unchanged.
- R6: A fill goes to an invalid way of the set first, choosing way 0 when both ways are invalid. When both ways are valid, the fill evicts the least recently used way. The two ways of a set never hold the same tag.
- R7: A load hit or a fill makes the used way the most recently used way of its set. A store never changes the replacement order.
- R8: A store is accepted in the cycle it is presented (`req_ready` 1, `stall` 0).
  - In that same cycle `mem_wr` is 1, with the store's address on `mem_addr` and its data on `mem_wdata`.
  - A store that hits updates the cached word in place.
  - A store that misses allocates no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Request completes this cycle |
| rd_data | output | 32 | Load result, valid when `req_ready` is 1 for a load |
| stall | output | 1 | Requester must hold its request |
| mem_rd | output | 1 | Main-memory read in progress |
| mem_wr | output | 1 | Main-memory write strobe (write-through) |
| mem_addr | output | 32 | Main-memory address |
| mem_wdata | output | 32 | Main-memory write data |
| mem_rdata | input | 32 | Main-memory read data, sampled in the last miss cycle |
| miss_total | output | 32 | Accumulated read-miss stall cycles |

## Verification
Hit data, store strobes and `req_ready` are combinational and are due in the very cycle a request is driven. The bench drives on the falling edge and samples 1 ns later, well before the next rising edge. A miss is followed cycle by cycle: `stall`, `mem_rd` and `mem_addr` are checked in each of the five penalty cycles, memory data is presented before the fifth rising edge, and the hit result is checked in the sixth cycle. The counter is compared after each load, since it changes at the edge that closes the first miss cycle. A bench-side model of the valid bits, tags, data and replacement order decides, ahead of each load, whether a hit or a miss is due.

// File: rtl/lru_cache_pkg.sv
package lru_cache_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WAYS   = 2;   // one LRU bit per set assumes two ways
  localparam int BYTE_W = 2;   // byte-in-word bits dropped from the address

  typedef enum logic {
    CTL_IDLE = 1'b0,
    CTL_FILL = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cache_ways.sv
module cache_ways
  import lru_cache_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic [WAYS-1:0]   hit_vec,
  output logic [WAYS-1:0]   valid_vec,
  output logic [DATA_W-1:0] hit_data,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] way_data [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   vld_d;
    logic [TAG_W-1:0]  tag_q [SETS];
    logic [DATA_W-1:0] dat_q [SETS];
    logic              sel;

    assign sel = wr_en && (wr_way == 1'(w));

    always_comb begin
      vld_d = vld_q;
      if (sel) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[wr_idx] <= wr_tag;
        dat_q[wr_idx] <= wr_data;
      end
    end

    assign valid_vec[w] = vld_q[lk_idx];
    assign hit_vec[w]   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign way_data[w]  = dat_q[lk_idx];
  end

  always_comb begin
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_data = hit_data | way_data[w];
    end
  end

  // R6: a tag is never resident twice in one set
  assert_single_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/lru_state.sv
module lru_state #(
  parameter int SETS  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             used_way,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             evict_way,
  output logic [SETS-1:0]  lru_vec
);
  logic [SETS-1:0] lru_q;
  logic [SETS-1:0] lru_d;

  // each bit names the way to evict next in its set
  always_comb begin
    lru_d = lru_q;
    if (upd_en) lru_d[upd_idx] = ~used_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  assign evict_way = lru_q[rd_idx];
  assign lru_vec   = lru_q;

  // R7: a used way is never the eviction choice right after use
  assert_used_is_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> (lru_q[$past(upd_idx)] == ~$past(used_way)));
endmodule

// File: rtl/miss_ctrl.sv
module miss_ctrl
  import lru_cache_pkg::*;
#(
  parameter int MISS_CYCLES = 5,
  parameter int CNT_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_miss,
  output logic             busy,
  output logic             fill_now,
  output logic [CNT_W-1:0] miss_total
);
  localparam int CW = $clog2(MISS_CYCLES + 1);

  ctl_state_e       st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [CNT_W-1:0] tot_q, tot_d;
  logic             last_cyc;

  assign last_cyc = (cnt_q == CW'(MISS_CYCLES - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    tot_d = tot_q;
    unique case (st_q)
      CTL_IDLE: begin
        if (start_miss) begin
          st_d  = CTL_FILL;
          cnt_d = CW'(1);
          tot_d = tot_q + CNT_W'(MISS_CYCLES);
        end
      end
      CTL_FILL: begin
        if (last_cyc) begin
          st_d  = CTL_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CTL_IDLE;
      cnt_q <= '0;
      tot_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tot_q <= tot_d;
    end
  end

  assign busy       = (st_q == CTL_FILL);
  assign fill_now   = busy && last_cyc;
  assign miss_total = tot_q;

  // R4: the penalty counter stays inside the five-cycle window
  assert_cnt_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0) && (cnt_q < CW'(MISS_CYCLES)));
  // R5: every miss entry adds exactly the penalty
  assert_penalty_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (tot_q == $past(tot_q) + CNT_W'(MISS_CYCLES)));
  // R5: outside miss entry the total holds
  assert_total_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_miss || busy |=> $stable(tot_q));
endmodule

// File: rtl/lru_word_cache.sv
module lru_word_cache
  import lru_cache_pkg::*;
#(
  parameter int SETS        = 4,
  parameter int MISS_CYCLES = 5,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              stall,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [CNT_W-1:0]  miss_total
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W - BYTE_W;

  logic [ADDR_W-1:0] miss_addr_q;
  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic [WAYS-1:0]   hit_vec;
  logic [WAYS-1:0]   valid_vec;
  logic [DATA_W-1:0] hit_data;
  logic              any_hit;
  logic              busy;
  logic              fill_now;
  logic              acc_load;
  logic              acc_store;
  logic              load_hit;
  logic              load_miss;
  logic              fill_way;
  logic              evict_way;
  logic [SETS-1:0]   lru_vec;
  logic              wr_en;
  logic              wr_way;
  logic [DATA_W-1:0] wr_data;
  logic              upd_en;
  logic              used_way;
  logic [BYTE_W-1:0] unused_byte_bits;

  assign unused_byte_bits = lk_addr[BYTE_W-1:0];

  // while a miss is open the lookup follows the latched miss address
  assign lk_addr = busy ? miss_addr_q : req_addr;
  assign lk_idx  = lk_addr[IDX_W+BYTE_W-1:BYTE_W];
  assign lk_tag  = lk_addr[ADDR_W-1:IDX_W+BYTE_W];

  assign any_hit   = |hit_vec;
  assign acc_load  = !busy && req_valid && !req_we;
  assign acc_store = !busy && req_valid && req_we;
  assign load_hit  = acc_load && any_hit;
  assign load_miss = acc_load && !any_hit;

  assign req_ready = load_hit || acc_store;
  assign stall     = busy || load_miss;
  assign rd_data   = load_hit ? hit_data : '0;

  assign mem_rd    = stall;
  assign mem_wr    = acc_store;
  assign mem_addr  = lk_addr;
  assign mem_wdata = req_wdata;

  // invalid way first (way 0 before way 1), else the LRU way
  always_comb begin
    if (!valid_vec[0])      fill_way = 1'b0;
    else if (!valid_vec[1]) fill_way = 1'b1;
    else                    fill_way = evict_way;
  end

  assign wr_en    = fill_now || (acc_store && any_hit);
  assign wr_way   = fill_now ? fill_way : hit_vec[1];
  assign wr_data  = fill_now ? mem_rdata : req_wdata;
  assign upd_en   = load_hit || fill_now;
  assign used_way = fill_now ? fill_way : hit_vec[1];

  always_ff @(posedge clk) begin
    if (load_miss) miss_addr_q <= req_addr;
  end

  cache_ways #(
    .SETS (SETS),
    .IDX_W(IDX_W),
    .TAG_W(TAG_W)
  ) ways_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (lk_idx),
    .lk_tag   (lk_tag),
    .hit_vec  (hit_vec),
    .valid_vec(valid_vec),
    .hit_data (hit_data),
    .wr_en    (wr_en),
    .wr_way   (wr_way),
    .wr_idx   (lk_idx),
    .wr_tag   (lk_tag),
    .wr_data  (wr_data)
  );

  lru_state #(
    .SETS (SETS),
    .IDX_W(IDX_W)
  ) lru_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .upd_idx  (lk_idx),
    .used_way (used_way),
    .rd_idx   (lk_idx),
    .evict_way(evict_way),
    .lru_vec  (lru_vec)
  );

  miss_ctrl #(
    .MISS_CYCLES(MISS_CYCLES),
    .CNT_W      (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_miss(load_miss),
    .busy      (busy),
    .fill_now  (fill_now),
    .miss_total(miss_total)
  );

  // R4: a stalled request never completes
  assert_stall_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_ready);
  // R4: a held load completes right after its fill
  assert_fill_then_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_now) && req_valid && !req_we && (req_addr == $past(mem_addr)))
      |-> req_ready);
  // R7: stores leave the replacement order alone
  assert_store_keeps_lru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_store |=> $stable(lru_vec));
  // R8: no write-through strobe while a miss is open
  assert_no_write_in_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !mem_wr);
endmodule

// File: tb/lru_word_cache_tb.sv
module lru_word_cache_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_we;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        req_ready;
  logic [31:0] rd_data;
  logic        stall;
  logic        mem_rd;
  logic        mem_wr;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic [31:0] miss_total;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench-side model built from the requirements
  logic        m_valid [2][4];
  logic [27:0] m_tag   [2][4];
  logic [31:0] m_data  [2][4];
  logic        m_lru   [4];
  logic [31:0] wmem    [logic [29:0]];
  logic [31:0] exp_total;

  lru_word_cache dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rd_data   (rd_data),
    .stall     (stall),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .miss_total(miss_total)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] memval(input logic [31:0] a);
    if (wmem.exists(a[31:2])) return wmem[a[31:2]];
    return {a[31:2], 2'b00} ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] mk_addr(input int tsel, input int set, input int lo);
    logic [27:0] t;
    t = 28'(tsel * 28'h0A3C5E1 + 28'h0000123);
    return {t, 2'(set), 2'(lo)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] a);
    logic [1:0]  s;
    logic [27:0] t;
    logic        h;
    int          hw;
    int          vw;
    s = a[3:2];
    t = a[31:4];
    h = 1'b0;
    hw = 0;
    for (int w = 0; w < 2; w++) begin
      if (m_valid[w][s] && m_tag[w][s] == t) begin h = 1'b1; hw = w; end
    end
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; mem_rdata = memval(a);
    #1;
    chk(stall == !h, "R6 R7", "hit or miss as expected (stall)", 32'(stall), 32'(!h));
    if (!h) begin
      for (int i = 0; i < 5; i++) begin
        if (i > 0) begin @(negedge clk); #1; end
        mem_rdata = memval(a);
        chk(stall && !req_ready, "R4", "stall held, not ready",
            {30'd0, stall, req_ready}, 32'h2);
        chk(mem_rd && mem_addr == a, "R4", "memory read address", mem_addr, a);
      end
      if (!m_valid[0][s])      vw = 0;
      else if (!m_valid[1][s]) vw = 1;
      else                     vw = int'(m_lru[s]);
      m_valid[vw][s] = 1'b1;
      m_tag[vw][s]   = t;
      m_data[vw][s]  = memval(a);
      hw = vw;
      exp_total = exp_total + 32'd5;
      @(negedge clk); #1;
    end
    chk(req_ready && !stall, "R3", "load completes", {30'd0, req_ready, stall}, 32'h2);
    chk(rd_data == m_data[hw][s], "R3", "load data", rd_data, m_data[hw][s]);
    m_lru[s] = ~1'(hw);
    chk(miss_total == exp_total, "R5", "miss cycle total", miss_total, exp_total);
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d);
    logic [1:0]  s;
    logic [27:0] t;
    s = a[3:2];
    t = a[31:4];
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    #1;
    chk(req_ready && !stall, "R8", "store accepted at once", {30'd0, req_ready, stall}, 32'h2);
    chk(mem_wr && mem_addr == a && mem_wdata == d, "R8", "write-through data", mem_wdata, d);
    wmem[a[31:2]] = d;
    for (int w = 0; w < 2; w++) begin
      if (m_valid[w][s] && m_tag[w][s] == t) m_data[w][s] = d;
    end
  endtask

  task automatic do_idle();
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    #1;
    chk(!stall && !mem_wr && !req_ready, "R1", "quiet when idle",
        {29'd0, stall, mem_wr, req_ready}, 32'h0);
    chk(miss_total == exp_total, "R5", "total holds when idle", miss_total, exp_total);
  endtask

  function automatic int conf_hit(input logic [31:0] a);
    for (int w = 0; w < 2; w++) begin
      if (m_valid[w][a[3:2]] && m_tag[w][a[3:2]] == a[31:4]) return 1;
    end
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog expired: actual=stuck expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [31:0] a;
    rst_n = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; mem_rdata = '0;
    exp_total = '0;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++) begin
        m_valid[w][s] = 1'b0; m_tag[w][s] = '0; m_data[w][s] = '0;
      end
    for (int s = 0; s < 4; s++) m_lru[s] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(!stall && miss_total == 0 && !mem_wr, "R1", "reset state", miss_total, 32'h0);

    // R1 / R6: first load misses, fills way 0; second tag fills way 1
    do_load(mk_addr(0, 1, 0));
    do_load(mk_addr(1, 1, 0));
    // R2: low two bits are ignored
    for (int lo = 1; lo < 4; lo++) begin
      do_load(mk_addr(0, 1, lo));
      chk(conf_hit(mk_addr(0, 1, lo)) == 1, "R2", "byte bits ignored", 32'(lo), 32'(lo));
    end
    // R7: store hit to tag 1 must not refresh it; tag 2 then evicts tag 1
    do_store(mk_addr(1, 1, 0), 32'hCAFE_0001);
    do_load(mk_addr(2, 1, 0));
    chk(conf_hit(mk_addr(1, 1, 0)) == 0, "R7", "store left way LRU, evicted", 0, 0);
    do_load(mk_addr(0, 1, 0));
    // R8: write-through value comes back from memory on refill
    do_load(mk_addr(1, 1, 0));
    // R8: store miss allocates nothing
    do_store(mk_addr(3, 2, 0), 32'h1234_5678);
    do_load(mk_addr(3, 2, 0));
    do_idle();

    // near-exhaustive sweep: every set, four tags, twice, loads then stores
    for (int pass = 0; pass < 2; pass++)
      for (int tg = 0; tg < 4; tg++)
        for (int s = 0; s < 4; s++) begin
          do_load(mk_addr(tg, s, (tg + s) % 4));
          if (pass == 1) do_store(mk_addr(tg, s, 0), 32'(tg * 16 + s) ^ 32'hBEEF_0000);
        end
    do_idle();

    // pseudo-random mix over the 16-word pool
    lfsr = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = mk_addr(int'(lfsr[3:2]), int'(lfsr[1:0]), int'(lfsr[5:4]));
      if (lfsr[8:6] == 3'd0)      do_idle();
      else if (lfsr[8:6] < 3'd3) do_store(a, {lfsr, ~lfsr});
      else                        do_load(a);
    end
    do_idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule